// File: doc/BRIEF.md
# Local Bus Ready Generator

This block produces the active-low ready strobe that closes each cycle on the processor's local bus. A cycle opens with a one-clock start strobe. Each clock that follows is one T-state, and the first clock after the start edge is T1. The generator counts T-states and pulls ready low for the single clock that is the cycle's last T-state.

The internal timer waits a number of T-states that depends on the address mode. It allows two T-states when addresses are pipelined and three when they are not. A wait count input adds further T-states beyond that minimum. Two kinds of cycle may instead be closed by an outside source as early as T2. The first is a coprocessor access, but only when the coprocessor-ready permission bit is set. The second is a read that hits in an external cache. In both cases the outside ready line is gated straight through to the output once T2 is reached. The internal timer keeps running as a fallback.

The cycle type, address mode, permission bit and wait count are captured at the start edge and held for the whole cycle. A start strobe given in the clock where ready is low is accepted at once, so back-to-back cycles run without a gap.

Top module: `lrg_ready_gen`

## Requirements
- R1: While reset is held, and until the first start strobe after it, `readyN` is 1.
- R2: In pipelined mode (`pipeMode`=1), an ordinary cycle (`cycType`=2'b00) with zero wait count drives `readyN` low in T2, and no cycle ever ends in T1.
- R3: In non-pipelined mode (`pipeMode`=0), the internal timer never ends a cycle before T3. An ordinary cycle with zero wait count ends in T3.
- R4: A wait count of n moves the internally timed end to T-state (2+n) in pipelined mode and (3+n) in non-pipelined mode, for n from 0 to the maximum count.
- R5: In a coprocessor cycle (`cycType`=2'b01) with `copReadyEn`=1, `copReadyN` low from T2 onward drives `readyN` low in that same clock. `copReadyN` low during T1 does not end the cycle.
- R6: When `copReadyEn`=0, `copReadyN` is ignored and a coprocessor cycle ends on the internal timer.
- R7: In a cache-hit read cycle (`cycType`=2'b10), `cacheReadyN` low from T2 onward drives `readyN` low in that same clock.
- R8: If the outside source of a coprocessor or cache-hit cycle stays inactive, the cycle still ends on the internal timer, wait count included.
- R9: The outside ready line that does not belong to the current cycle's type has no effect. Type code 2'b11 is timed like an ordinary cycle.
- R10: `readyN` is low for exactly one clock per cycle and is never low while no cycle is in progress.
- R11: A start strobe given in the clock where `readyN` is low makes the next clock T1 of a new cycle.
- R12: A start strobe given during any earlier T-state of an open cycle is ignored.
- R13: Mode, type, permission bit and wait count are sampled at the start edge. Changing them later in the cycle does not alter its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T-state per period |
| rstN | input | 1 | Active-low synchronous reset |
| cycStart | input | 1 | High for one clock before T1 of a new cycle |
| pipeMode | input | 1 | 1 = pipelined addressing (two-state minimum), 0 = three-state minimum |
| cycType | input | 2 | 00 ordinary, 01 coprocessor, 10 cache-hit read, 11 timed as ordinary |
| copReadyEn | input | 1 | Permits the coprocessor's ready to close coprocessor cycles |
| waitCnt | input | WAIT_W | Extra T-states added to the internal minimum |
| copReadyN | input | 1 | Active-low ready from the coprocessor |
| cacheReadyN | input | 1 | Active-low ready from the external cache on a hit |
| readyN | output | 1 | Active-low combined ready, low in the cycle's last T-state |

## Verification
The bench builds the block with the default WAIT_W of 3, so wait counts range from 0 to 7. This covers both the shortest pipelined cycle of two T-states and the longest non-pipelined cycle of ten. With that range, a cycle can be set up where an outside ready arrives either before or after the internal deadline. The bench then checks that whichever comes first closes the cycle. A three-bit counter is also narrow enough to check the T-state counter's width at the top count.

// File: rtl/lrg_pkg.sv
package lrg_pkg;

  typedef enum logic [1:0] {
    CYC_ORD   = 2'b00,
    CYC_COP   = 2'b01,
    CYC_CACHE = 2'b10,
    CYC_RSVD  = 2'b11
  } cycKind_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_COP   = 2'b01,
    SRC_CACHE = 2'b10
  } extSrc_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic clear;
  } lrgStrobe_t;

  localparam int unsigned MIN_PIPE   = 2;
  localparam int unsigned MIN_NOPIPE = 3;
  localparam int unsigned EXT_EARLY  = 2;

  function automatic int unsigned minStates(input logic pipe);
    return pipe ? MIN_PIPE : MIN_NOPIPE;
  endfunction

  function automatic extSrc_t pickSource(input cycKind_t kind, input logic copEn);
    case (kind)
      CYC_COP:   return copEn ? SRC_COP : SRC_NONE;
      CYC_CACHE: return SRC_CACHE;
      default:   return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lrg_control.sv
module lrg_control
  import lrg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycStart,
  input  logic       cycEnd,
  output lrgStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_BUSY} ctlState_t;

  ctlState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (cycStart) begin
          strobe.load = 1'b1;
          stateD      = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (cycEnd) begin
          if (cycStart) begin
            strobe.load = 1'b1;
          end else begin
            strobe.clear = 1'b1;
            stateD       = ST_IDLE;
          end
        end else begin
          strobe.advance = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/lrg_datapath.sv
module lrg_datapath
  import lrg_pkg::*;
#(
  parameter int unsigned WAIT_W = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrgStrobe_t        strobe,
  input  logic              pipeMode,
  input  logic [1:0]        cycType,
  input  logic              copReadyEn,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic              copReadyN,
  input  logic              cacheReadyN,
  output logic              cycEnd
);

  localparam logic [CNT_W-1:0] CNT_TOP   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_EXT   = CNT_W'(EXT_EARLY);

  logic             activeQ;
  logic [CNT_W-1:0] tCountQ;
  logic [CNT_W-1:0] targetQ;
  extSrc_t          srcQ;

  logic [CNT_W-1:0] targetD;
  logic             extLive;
  logic             intDone;
  logic             extDone;

  always_comb begin
    targetD = CNT_W'(minStates(pipeMode)) + CNT_W'(waitCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      tCountQ <= '0;
      targetQ <= '0;
      srcQ    <= SRC_NONE;
    end else if (strobe.load) begin
      activeQ <= 1'b1;
      tCountQ <= CNT_FIRST;
      targetQ <= targetD;
      srcQ    <= pickSource(cycKind_t'(cycType), copReadyEn);
    end else if (strobe.clear) begin
      activeQ <= 1'b0;
      tCountQ <= '0;
      srcQ    <= SRC_NONE;
    end else if (strobe.advance && tCountQ != CNT_TOP) begin
      tCountQ <= tCountQ + CNT_W'(1);
    end
  end

  always_comb begin
    case (srcQ)
      SRC_COP:   extLive = ~copReadyN;
      SRC_CACHE: extLive = ~cacheReadyN;
      default:   extLive = 1'b0;
    endcase
  end

  assign intDone = activeQ && (tCountQ == targetQ);
  assign extDone = activeQ && (tCountQ >= CNT_EXT) && extLive;
  assign cycEnd  = intDone || extDone;

endmodule

// File: rtl/lrg_ready_gen.sv
module lrg_ready_gen
  import lrg_pkg::*;
#(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycStart,
  input  logic              pipeMode,
  input  logic [1:0]        cycType,
  input  logic              copReadyEn,
  input  logic [WAIT_W-1:0] waitCnt,
  input  logic              copReadyN,
  input  logic              cacheReadyN,
  output logic              readyN
);

  localparam int unsigned MAX_STATES = MIN_NOPIPE + (2 ** WAIT_W) - 1;
  localparam int unsigned CNT_W      = $clog2(MAX_STATES + 1);

  lrgStrobe_t strobe;
  logic       cycEnd;

  lrg_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .cycEnd   (cycEnd),
    .strobe   (strobe)
  );

  lrg_datapath #(
    .WAIT_W (WAIT_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pipeMode    (pipeMode),
    .cycType     (cycType),
    .copReadyEn  (copReadyEn),
    .waitCnt     (waitCnt),
    .copReadyN   (copReadyN),
    .cacheReadyN (cacheReadyN),
    .cycEnd      (cycEnd)
  );

  assign readyN = ~cycEnd;

endmodule

// File: rtl/lrg_ready_checker.sv
module lrg_ready_checker
  import lrg_pkg::*;
#(
  parameter int unsigned WAIT_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycStart,
  input logic              pipeMode,
  input logic [1:0]        cycType,
  input logic              copReadyEn,
  input logic [WAIT_W-1:0] waitCnt,
  input logic              readyN
);

  localparam int unsigned SH_W = $clog2(MIN_NOPIPE + (2 ** WAIT_W)) + 1;

  logic            busyS;
  logic [SH_W-1:0] tS;
  logic [SH_W-1:0] tgtS;
  logic            pipeS;
  logic            extOkS;
  logic            copOffS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyS   <= 1'b0;
      tS      <= '0;
      tgtS    <= '0;
      pipeS   <= 1'b0;
      extOkS  <= 1'b0;
      copOffS <= 1'b0;
    end else if (!busyS || !readyN) begin
      if (cycStart) begin
        busyS   <= 1'b1;
        tS      <= SH_W'(1);
        tgtS    <= SH_W'(pipeMode ? 2 : 3) + SH_W'(waitCnt);
        pipeS   <= pipeMode;
        extOkS  <= (cycType == 2'b10) || (cycType == 2'b01 && copReadyEn);
        copOffS <= (cycType == 2'b01) && !copReadyEn;
      end else begin
        busyS <= 1'b0;
      end
    end else begin
      tS <= tS + SH_W'(1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> readyN); // R1
  AST_NEVER_T1: assert property (@(posedge clk) disable iff (!rstN) !readyN |-> (busyS && tS >= SH_W'(2))); // R2
  AST_NONPIPE_MIN: assert property (@(posedge clk) disable iff (!rstN) (!readyN && !pipeS && !extOkS) |-> tS >= SH_W'(3)); // R3
  AST_WAIT_DEADLINE: assert property (@(posedge clk) disable iff (!rstN) (busyS && tS == tgtS) |-> !readyN); // R4
  AST_COP_GATED: assert property (@(posedge clk) disable iff (!rstN) (busyS && copOffS && tS < tgtS) |-> readyN); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN) !readyN |=> readyN); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !busyS |-> readyN); // R10

endmodule

bind lrg_ready_gen lrg_ready_checker #(.WAIT_W(WAIT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycStart   (cycStart),
  .pipeMode   (pipeMode),
  .cycType    (cycType),
  .copReadyEn (copReadyEn),
  .waitCnt    (waitCnt),
  .readyN     (readyN)
);

// File: tb/lrg_ready_gen_tb.sv
module lrg_ready_gen_tb_top;

  localparam int unsigned WAIT_W = 3;
  localparam int unsigned WATCHDOG = 5000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cycStart = 1'b0;
  logic              pipeMode = 1'b1;
  logic [1:0]        cycType = 2'b00;
  logic              copReadyEn = 1'b0;
  logic [WAIT_W-1:0] waitCnt = '0;
  logic              copReadyN = 1'b1;
  logic              cacheReadyN = 1'b1;
  logic              readyN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lrg_ready_gen #(.WAIT_W(WAIT_W)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .cycStart    (cycStart),
    .pipeMode    (pipeMode),
    .cycType     (cycType),
    .copReadyEn  (copReadyEn),
    .waitCnt     (waitCnt),
    .copReadyN   (copReadyN),
    .cacheReadyN (cacheReadyN),
    .readyN      (readyN)
  );

  // {pipe, type[1:0], copEn, waits[2:0], extSel, extAt[3:0], expEnd[3:0]}
  // extSel 0 drives copReadyN, 1 drives cacheReadyN; extAt 0 means never
  localparam int NVEC = 14;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 2'b00, 1'b0, 3'd0, 1'b0, 4'd0, 4'd2},   // R2
    {1'b0, 2'b00, 1'b0, 3'd0, 1'b0, 4'd0, 4'd3},   // R3
    {1'b1, 2'b00, 1'b0, 3'd3, 1'b0, 4'd0, 4'd5},   // R4
    {1'b0, 2'b00, 1'b0, 3'd7, 1'b0, 4'd0, 4'd10},  // R4
    {1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 4'd2, 4'd2},   // R5
    {1'b0, 2'b01, 1'b1, 3'd0, 1'b0, 4'd1, 4'd2},   // R5 T1 ignored
    {1'b0, 2'b01, 1'b0, 3'd0, 1'b0, 4'd2, 4'd3},   // R6
    {1'b0, 2'b10, 1'b0, 3'd0, 1'b1, 4'd2, 4'd2},   // R7
    {1'b1, 2'b10, 1'b0, 3'd4, 1'b1, 4'd4, 4'd4},   // R7
    {1'b0, 2'b10, 1'b0, 3'd2, 1'b1, 4'd0, 4'd5},   // R8
    {1'b0, 2'b01, 1'b1, 3'd1, 1'b0, 4'd0, 4'd4},   // R8
    {1'b0, 2'b00, 1'b0, 3'd0, 1'b1, 4'd2, 4'd3},   // R9
    {1'b0, 2'b11, 1'b1, 3'd0, 1'b1, 4'd2, 4'd3},   // R9
    {1'b1, 2'b01, 1'b0, 3'd5, 1'b1, 4'd3, 4'd7}    // R9
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic runCycle(input logic p, input logic [1:0] ty, input logic en,
                          input logic [2:0] w, input logic sel, input int extAt,
                          input int expEnd, input string req);
    int endT;
    endT = 0;
    @(negedge clk);
    pipeMode = p; cycType = ty; copReadyEn = en; waitCnt = w; cycStart = 1'b1;
    @(negedge clk);
    cycStart = 1'b0;
    for (int t = 1; t <= 14; t++) begin
      if (extAt != 0 && t >= extAt) begin
        if (sel) cacheReadyN = 1'b0;
        else     copReadyN = 1'b0;
      end
      #1;
      if (!readyN) begin
        endT = t;
        break;
      end
      @(negedge clk);
    end
    check(endT == expEnd, req, endT, expEnd);
    @(negedge clk);
    copReadyN = 1'b1; cacheReadyN = 1'b1;
    #1;
    check(readyN == 1'b1, "R10", readyN, 1);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check(readyN == 1'b1, "R1", readyN, 1);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(readyN == 1'b1, "R1", readyN, 1);
    end

    // table-driven cycles
    for (int v = 0; v < NVEC; v++) begin
      runCycle(VEC[v][15], VEC[v][14:13], VEC[v][12], VEC[v][11:9], VEC[v][8],
               int'(VEC[v][7:4]), int'(VEC[v][3:0]),
               $sformatf("vec%0d R2-table", v));
    end

    // R11: start in the ready clock chains a new cycle
    @(negedge clk);
    pipeMode = 1'b1; cycType = 2'b00; waitCnt = '0; copReadyEn = 1'b0; cycStart = 1'b1;
    @(negedge clk); cycStart = 1'b0; #1;
    check(readyN == 1'b1, "R11", readyN, 1);
    @(negedge clk); cycStart = 1'b1; #1;
    check(readyN == 1'b0, "R11", readyN, 0);
    @(negedge clk); cycStart = 1'b0; #1;
    check(readyN == 1'b1, "R11", readyN, 1);
    @(negedge clk); #1;
    check(readyN == 1'b0, "R11", readyN, 0);
    @(negedge clk); #1;
    check(readyN == 1'b1, "R11", readyN, 1);

    // R12: start inside an open cycle is dropped
    @(negedge clk);
    pipeMode = 1'b0; waitCnt = 3'd2; cycStart = 1'b1;
    @(negedge clk); cycStart = 1'b0;
    @(negedge clk); cycStart = 1'b1;
    @(negedge clk); cycStart = 1'b0;
    @(negedge clk);
    @(negedge clk); #1;
    check(readyN == 1'b0, "R12", readyN, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check(readyN == 1'b1, "R12", readyN, 1);
    end

    // R13: inputs changed after the start edge are not used
    @(negedge clk);
    pipeMode = 1'b1; cycType = 2'b00; waitCnt = '0; cycStart = 1'b1;
    @(negedge clk);
    cycStart = 1'b0; pipeMode = 1'b0; waitCnt = 3'd7; cycType = 2'b10;
    #1;
    check(readyN == 1'b1, "R13", readyN, 1);
    @(negedge clk); #1;
    check(readyN == 1'b0, "R13", readyN, 0);
    @(negedge clk); #1;
    check(readyN == 1'b1, "R13", readyN, 1);
    cycType = 2'b00; waitCnt = '0;

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule